// File: doc/BRIEF.md
# Burst Address Generator with Load Arbitration

This block keeps the word address for a synchronous burst memory. A new start address is captured when one of two active-low address strobes is asserted. The controller strobe loads whatever the chip-enable input says. The processor strobe loads only while the active-low chip enable is asserted.

After a load, the block walks the low address bits through a burst of 2^BW beats (four beats by default). A static mode input picks one of two orders. In interleaved order, each beat XORs the beat index into the start bits. In linear order, each beat adds the beat index to the start bits and wraps within the burst. An active-low advance input steps the burst by one beat per clock. While advance is high, the address is frozen, which inserts a wait state. The upper address bits never change during a burst.

The memory core reads the full current address and the beat index directly from the outputs.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, the current address and the beat index are both zero.
- R2: With the controller strobe low at a rising edge, the address loads from the address input and the beat index becomes zero, whatever the chip-enable level.
- R3: With the processor strobe low and chip enable low at a rising edge, the address loads from the address input and the beat index becomes zero.
- R4: With the processor strobe low, chip enable high, the controller strobe high and advance high, the current address and beat index do not change.
- R5: With the mode input at 1 (interleaved), the two low address bits equal the start low bits XOR the beat index. From start 01 the order is 01, 00, 11, 10.
- R6: With the mode input at 0 (linear), the two low address bits equal the start low bits plus the beat index, modulo 4. From start 11 the order is 11, 00, 01, 10.
- R7: An advance after the fourth beat returns the beat index to 0 and the low bits to their start value.
- R8: When no load occurs and advance is high at a rising edge, the address and beat index hold.
- R9: A load takes priority over advance in the same cycle. The new address appears with beat index 0.
- R10: When no load occurs, the address bits above the low two bits do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable; qualifies the processor strobe only |
| ctl_stb_n | input | 1 | Active-low controller address strobe, not qualified |
| cpu_stb_n | input | 1 | Active-low processor address strobe |
| adv_n | input | 1 | Active-low burst advance |
| interleave | input | 1 | Static burst order: 1 interleaved, 0 linear |
| addr_in | input | AW (15) | Start address captured on a load |
| cur_addr | output | AW (15) | Current word address |
| beat | output | BW (2) | Beat index within the burst |

## Verification
The order properties assume that the mode input is static. Each of them checks only cycles in which the mode is the same on both sides of the edge. The stimulus changes the mode only in a cycle that also loads a new address, so every burst runs under one mode. The strobes, chip enable and advance input are driven in every combination that matters, including both strobes at once and a load together with an advance. All inputs change at the falling edge.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 15,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          ctl_stb_n,
  input  logic          cpu_stb_n,
  input  logic          adv_n,
  input  logic          interleave,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] cur_addr,
  output logic [BW-1:0] beat
);
  localparam int HI = AW - BW;

  logic          take;
  logic [AW-1:0] base_q;
  logic [BW-1:0] cnt_q;
  logic [BW-1:0] low;

  assign take = !ctl_stb_n || (!cpu_stb_n && !ce_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (take) begin
      base_q <= addr_in;
      cnt_q  <= '0;
    end else if (!adv_n) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign low      = interleave ? (base_q[BW-1:0] ^ cnt_q) : (base_q[BW-1:0] + cnt_q);
  assign cur_addr = {base_q[AW-1:BW], low};
  assign beat     = cnt_q;

  logic [HI-1:0] unused_hi;
  assign unused_hi = base_q[AW-1:BW];
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW = 15,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          ctl_stb_n,
  input logic          cpu_stb_n,
  input logic          adv_n,
  input logic          interleave,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] cur_addr,
  input logic [BW-1:0] beat
);
  logic ld;
  assign ld = !ctl_stb_n || (!cpu_stb_n && !ce_n);

  assert_ctl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_stb_n |=> (cur_addr[AW-1:BW] == $past(addr_in[AW-1:BW])) && (beat == '0));

  assert_cpu_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stb_n && !ce_n) |=> (cur_addr[AW-1:BW] == $past(addr_in[AW-1:BW])) && (beat == '0));

  assert_cpu_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stb_n && ce_n && ctl_stb_n && adv_n && $stable(interleave)) |=> $stable(cur_addr) && $stable(beat));

  assert_interleave_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (interleave && !ld) |=> (!interleave || ((cur_addr[BW-1:0] ^ beat) == $past(cur_addr[BW-1:0] ^ beat))));

  assert_linear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!interleave && !ld) |=> (interleave || ((cur_addr[BW-1:0] - beat) == $past(cur_addr[BW-1:0] - beat))));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && adv_n) |=> $stable(beat));

  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !adv_n) |=> beat == $past(beat) + 1'b1);

  assert_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !adv_n) |=> beat == '0);

  assert_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(cur_addr[AW-1:BW]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW), .BW(BW)) i_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ctl_stb_n(ctl_stb_n),
  .cpu_stb_n(cpu_stb_n), .adv_n(adv_n), .interleave(interleave),
  .addr_in(addr_in), .cur_addr(cur_addr), .beat(beat)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 15;
  localparam int BW = 2;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          ctl_stb_n = 1'b1;
  logic          cpu_stb_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          interleave = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] cur_addr;
  logic [BW-1:0] beat;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [AW+BW-1:0] exp_q[$];
  string            tag_q[$];

  logic [AW-1:0] m_base = '0;
  logic [BW-1:0] m_cnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.AW(AW), .BW(BW)) i_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ctl_stb_n(ctl_stb_n),
    .cpu_stb_n(cpu_stb_n), .adv_n(adv_n), .interleave(interleave),
    .addr_in(addr_in), .cur_addr(cur_addr), .beat(beat)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [BW-1:0] lo;
    lo = interleave ? (m_base[BW-1:0] ^ m_cnt) : (m_base[BW-1:0] + m_cnt);
    return {m_base[AW-1:BW], lo};
  endfunction

  task automatic check(input string tag, input logic [AW+BW-1:0] act, input logic [AW+BW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, act[AW+BW-1:BW], act[BW-1:0], exp[AW+BW-1:BW], exp[BW-1:0]);
    end
  endtask

  task automatic step(input logic ctl, input logic cpu, input logic ce, input logic adv,
                      input logic mode, input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    ctl_stb_n = ctl; cpu_stb_n = cpu; ce_n = ce; adv_n = adv; interleave = mode; addr_in = a;
    @(posedge clk);
    #1;
    if (!ctl || (!cpu && !ce)) begin
      m_base = a;
      m_cnt  = '0;
    end else if (!adv) begin
      m_cnt = m_cnt + 1'b1;
    end
    exp_q.push_back({model_addr(), m_cnt});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      check(tag_q.pop_front(), {cur_addr, beat}, exp_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    check("R1 reset", {cur_addr, beat}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    step(0, 1, 1, 1, 1, 15'h1235, "R2 ctl load ce high");
    step(1, 1, 1, 0, 1, 15'h0000, "R5 interleave beat1");
    step(1, 1, 1, 0, 1, 15'h0000, "R5 interleave beat2");
    step(1, 1, 1, 0, 1, 15'h0000, "R10 interleave beat3");
    step(1, 1, 1, 0, 1, 15'h0000, "R7 wrap interleave");
    step(1, 1, 1, 0, 1, 15'h0000, "R5 second lap");
    step(1, 1, 1, 1, 1, 15'h7FFF, "R8 hold");
    step(1, 1, 0, 1, 1, 15'h7FFF, "R8 hold ce low");
    step(1, 0, 1, 1, 1, 15'h7FFF, "R4 cpu strobe gated");
    step(1, 0, 1, 0, 1, 15'h7FFF, "R4 gated strobe with advance");
    step(1, 0, 0, 0, 1, 15'h4AAA, "R3 R9 cpu load with advance");
    step(1, 1, 1, 0, 1, 15'h0000, "R5 interleave from 10");
    step(0, 0, 0, 1, 0, 15'h0003, "R2 both strobes, linear mode");
    step(1, 1, 1, 0, 0, 15'h0000, "R6 linear beat1");
    step(1, 1, 1, 1, 0, 15'h0000, "R8 linear wait");
    step(1, 1, 1, 0, 0, 15'h0000, "R6 linear beat2");
    step(1, 1, 1, 0, 0, 15'h0000, "R10 linear beat3");
    step(1, 1, 1, 0, 0, 15'h0000, "R7 wrap linear");
    step(1, 1, 1, 0, 0, 15'h0000, "R6 linear beat1 again");
    step(0, 1, 1, 0, 0, 15'h2C05, "R9 ctl load mid burst");
    step(1, 1, 1, 0, 0, 15'h0000, "R6 linear from 01");
    step(1, 1, 1, 0, 0, 15'h0000, "R6 linear 11");
    step(1, 0, 0, 1, 0, 15'h5556, "R3 cpu load no advance");
    step(1, 1, 1, 0, 0, 15'h0000, "R6 linear from 10");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule